// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost Thresholds

This block is a first-in first-out buffer of 64 words of 36 bits that sits between two clock domains that need not be related. A producer in the write domain pushes words with a chip select and an enable. A consumer in the read domain pulls them out the same way. Each side has its own status flags, and each flag is timed only by that side's clock. The write and read pointers are 7 bits wide. Each pointer crosses into the other domain in Gray code through a two-stage synchronizer. Each side compares its own pointer with the synchronized copy of the other.

Seen as a stream, `full_n` is the write side's ready and `empty_n` is the read side's valid. A write is accepted on a rising `wclk` edge only when `wr_cs_n` is low, `wr_en` is high and `full_n` is high. Otherwise `wr_data` is ignored and the producer must hold or retry the word itself. A read is accepted on a rising `rclk` edge only when `rd_cs_n` is low, `rd_en` is high and `empty_n` is high. The word then appears on `rd_data` just after that edge and stays there until the next accepted read.

One offset value X sets both almost thresholds. `ofs_sel` chooses X from four presets, and its value is captured when reset ends. Because the flags are built from synchronized pointers, they free up space or show data two edges late. They never report capacity that is not really there.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, `empty_n`, `full_n`, `aempty_n` and `afull_n` are all low, and `rd_data` reads zero.
- R2: After `rst_n` rises, `full_n` stays low through the first rising `wclk` edge and goes high after the second.
- R3: A read happens only on a rising `rclk` edge with `rd_cs_n` low, `rd_en` high and `empty_n` high. The oldest stored word then appears on `rd_data` after that edge, and `rd_data` holds its value when no read happens.
- R4: A write happens only on a rising `wclk` edge with `wr_cs_n` low, `wr_en` high and `full_n` high. A write attempted while `full_n` is low, or with `wr_cs_n` high, is discarded and never comes out.
- R5: `empty_n` goes high after the second rising `rclk` edge that follows a write into an empty buffer. It goes low right after the edge that reads the last visible word.
- R6: `full_n` goes low right after the edge that stores the 64th word. It goes high again after the second rising `wclk` edge that follows a read.
- R7: `aempty_n` is low whenever the number of words visible to the read side is at most X, and high otherwise.
- R8: `afull_n` is low whenever the number of free locations seen by the write side is at most X, and high otherwise (and low until `full_n` first rises).
- R9: X is 16, 12, 8 or 4 for `ofs_sel` codes 2'b00, 2'b01, 2'b10 and 2'b11. Each side captures the code at its first rising clock edge after reset ends, and later changes of `ofs_sel` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| ofs_sel | input | 2 | Preset select for the almost threshold, captured when reset ends |
| wclk | input | 1 | Write-domain clock |
| wr_cs_n | input | 1 | Write chip select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when full or in reset; write-side ready |
| afull_n | output | 1 | Low when free locations are at or below X |
| rclk | input | 1 | Read-domain clock |
| rd_cs_n | input | 1 | Read chip select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 36 | Registered output word |
| empty_n | output | 1 | Low when empty or in reset; read-side valid |
| aempty_n | output | 1 | Low when stored words are at or below X |

## Verification
The risky overlap is a write and a read landing on the same edge while one of the flags sits at its limit. Examples are a word stored as the last one is drained, or a read that frees a slot on the edge where the buffer became full. The bench drives both clocks from one source, so every edge carries both operations. It runs long random phases that push toward full and then toward empty, followed by a stretch of back-to-back read and write on a full buffer. On every cycle it compares all four flags and `rd_data` against a queue model in which each side sees the other's count two edges late.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Threshold chosen by a 2-bit select: base minus step per code value.
  function automatic int unsigned preset_offset(input logic [1:0] code,
                                                input int unsigned base,
                                                input int unsigned step);
    return base - step * {30'd0, code};
  endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW    = 36,
  parameter int AW    = 6,
  parameter int DEPTH = 64
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int          DEPTH    = 64,
  parameter int unsigned OFS_BASE = 16,
  parameter int unsigned OFS_STEP = 4
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          en,
  input  logic [1:0]    ofs_sel,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wbin,
  output logic          full_n,
  output logic          afull_n
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin_s, used, free, xoff, wbin_nx;
  logic [1:0]    live;

  assign rbin_s  = g2b(rgray_s);
  assign used    = wbin - rbin_s;
  assign free    = DEPTH_V - used;
  assign full_n  = live[1] & (used != DEPTH_V);
  assign afull_n = live[1] & (free > xoff);
  assign we      = ~cs_n & en & full_n;
  assign waddr   = wbin[AW-1:0];
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      live  <= '0;
    end else begin
      live <= {live[0], 1'b1};
      if (we) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  // Offset follows the select until the first edge after reset, then holds.
  always_ff @(posedge wclk) begin
    if (!live[0]) xoff <= PW'(preset_offset(ofs_sel, OFS_BASE, OFS_STEP));
  end

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int unsigned OFS_BASE = 16,
  parameter int unsigned OFS_STEP = 4
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          en,
  input  logic [1:0]    ofs_sel,
  input  logic [AW:0]   wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rbin,
  output logic          empty_n,
  output logic          aempty_n
);

  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_s, avail, xoff, rbin_nx;
  logic          live;

  assign wbin_s   = g2b(wgray_s);
  assign avail    = wbin_s - rbin;
  assign empty_n  = (avail != '0);
  assign aempty_n = live & (avail > xoff);
  assign re       = ~cs_n & en & empty_n;
  assign raddr    = rbin[AW-1:0];
  assign rbin_nx  = rbin + PW'(1);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      live  <= 1'b0;
    end else begin
      live <= 1'b1;
      if (re) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (!live) xoff <= PW'(preset_offset(ofs_sel, OFS_BASE, OFS_STEP));
  end

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcf_pkg::*;
#(
  parameter int          DW       = 36,
  parameter int          AW       = 6,
  parameter int unsigned OFS_BASE = 16,
  parameter int unsigned OFS_STEP = 4
) (
  input  logic          rst_n,
  input  logic [1:0]    ofs_sel,
  input  logic          wclk,
  input  logic          wr_cs_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rclk,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [PW-1:0] wr_ptr, rd_ptr;

  dcf_wr_ctl #(.AW(AW), .DEPTH(DEPTH), .OFS_BASE(OFS_BASE), .OFS_STEP(OFS_STEP)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .cs_n(wr_cs_n), .en(wr_en), .ofs_sel(ofs_sel),
    .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray), .wbin(wr_ptr),
    .full_n(full_n), .afull_n(afull_n)
  );

  dcf_rd_ctl #(.AW(AW), .OFS_BASE(OFS_BASE), .OFS_STEP(OFS_STEP)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .cs_n(rd_cs_n), .en(rd_en), .ofs_sel(ofs_sel),
    .wgray_s(wgray_s), .re(re), .raddr(raddr), .rgray(rgray), .rbin(rd_ptr),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  dcf_gray_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_gray_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_ram #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int DEPTH = 64,
  parameter int PW    = 7
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);

  // R4: a low full flag leaves the write pointer where it is
  a_r4_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));

  // R3: a low empty flag leaves the read pointer where it is
  a_r3_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr));

  // R6: stored words never exceed the depth
  a_r6_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (PW'(wptr - rptr) <= PW'(DEPTH)));

  // R8: full implies almost full
  a_r8_af_covers_full: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R7: empty implies almost empty
  a_r7_ae_covers_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wptr(wr_ptr), .rptr(rd_ptr)
);

// File: tb/test_dcfifo_pflag.sv
module test_dcfifo_pflag;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ofs_sel = 2'b00;
  logic        wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        full_n, afull_n, empty_n, aempty_n;
  logic [35:0] rd_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dcfifo_pflag i_dcfifo_pflag (
    .rst_n(rst_n), .ofs_sel(ofs_sel), .wclk(clk), .wr_cs_n(wr_cs_n), .wr_en(wr_en),
    .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n), .rclk(clk),
    .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n),
    .aempty_n(aempty_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  logic [35:0] q[$];
  bit [6:0]    mw, mr, mw_s1, mw_s2, mr_s1, mr_s2;
  bit [1:0]    wlive;
  bit          rlive;
  int          xw, xr;
  logic [35:0] m_data;

  function automatic int ofs_of(input logic [1:0] c);
    return 16 - 4 * int'(c);
  endfunction
  function automatic bit m_full_n();
    return wlive[1] && (7'(mw - mr_s2) != 7'd64);
  endfunction
  function automatic bit m_afull_n();
    return wlive[1] && ((DEPTH - int'(7'(mw - mr_s2))) > xw);
  endfunction
  function automatic bit m_empty_n();
    return mr != mw_s2;
  endfunction
  function automatic bit m_aempty_n();
    return rlive && (int'(7'(mw_s2 - mr)) > xr);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      mw = 0; mr = 0; mw_s1 = 0; mw_s2 = 0; mr_s1 = 0; mr_s2 = 0;
      wlive = 0; rlive = 0; m_data = '0;
      xw = ofs_of(ofs_sel); xr = ofs_of(ofs_sel);
    end else begin
      bit wok, rok;
      wok = !wr_cs_n && wr_en && m_full_n();
      rok = !rd_cs_n && rd_en && m_empty_n();
      if (!wlive[0]) xw = ofs_of(ofs_sel);
      if (!rlive)    xr = ofs_of(ofs_sel);
      mw_s2 = mw_s1; mw_s1 = mw;
      mr_s2 = mr_s1; mr_s1 = mr;
      if (wok) begin q.push_back(wr_data); mw = mw + 7'd1; end
      if (rok) begin m_data = q.pop_front(); mr = mr + 7'd1; end
      wlive = {wlive[0], 1'b1};
      rlive = 1'b1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R5 empty_n", 64'(empty_n), 64'(m_empty_n()));
    chk("R6 full_n", 64'(full_n), 64'(m_full_n()));
    chk("R7 aempty_n", 64'(aempty_n), 64'(m_aempty_n()));
    chk("R8 afull_n", 64'(afull_n), 64'(m_afull_n()));
    chk("R3 rd_data", 64'(rd_data), 64'(m_data));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    wr_cs_n = 1'b1; wr_en = 1'b0; rd_cs_n = 1'b1; rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    idle();
    ofs_sel = sel;
    rst_n = 1'b0;
    repeat (3) tick();
    // R1: flags all low while held in reset
    chk("R1 flags in reset", 64'({empty_n, full_n, aempty_n, afull_n}), 64'(0));
    chk("R1 rd_data in reset", 64'(rd_data), 64'(0));
    rst_n = 1'b1;
    tick();
    chk("R2 full_n after first edge", 64'(full_n), 64'(0));
    tick();
    chk("R2 full_n after second edge", 64'(full_n), 64'(1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Phase 1: X = 16, fill past full
    do_reset(2'b00);
    for (int i = 0; i < 70; i++) begin
      wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = {4'h5, 32'(i)};
      tick();
    end
    idle(); repeat (3) tick();
    for (int i = 0; i < 70; i++) begin
      rd_cs_n = 1'b0; rd_en = 1'b1;
      tick();
    end
    idle(); repeat (3) tick();
    // R4: the six writes tried while full never come out
    chk("R4 last drained word", 64'(rd_data), 64'({4'h5, 32'd63}));

    // Phase 2: chip select high blocks transfers
    wr_cs_n = 1'b1; wr_en = 1'b1; wr_data = 36'hABC;
    repeat (4) tick();
    idle(); repeat (3) tick();
    chk("R4 deselected write ignored", 64'(empty_n), 64'(0));
    wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = 36'h123456789;
    tick();
    idle(); repeat (3) tick();
    rd_cs_n = 1'b1; rd_en = 1'b1;
    repeat (3) tick();
    chk("R3 deselected read ignored", 64'({empty_n, 36'(rd_data)}), 64'({1'b1, 36'({4'h5, 32'd63})}));
    idle(); rd_cs_n = 1'b0; rd_en = 1'b1;
    tick();
    idle(); tick();
    chk("R3 word after read", 64'(rd_data), 64'(36'h123456789));

    // Phase 3: R9 capture of select code 01 (X = 12), later change ignored
    do_reset(2'b01);
    ofs_sel = 2'b00;
    for (int i = 0; i < 12; i++) begin
      wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = 36'(i);
      tick();
    end
    idle(); repeat (3) tick();
    chk("R9 aempty_n at 12 words with X=12", 64'(aempty_n), 64'(0));
    wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = 36'h77;
    tick();
    idle(); repeat (3) tick();
    chk("R9 aempty_n at 13 words with X=12", 64'(aempty_n), 64'(1));

    // Phase 4: X = 4, random simultaneous traffic biased toward full then empty
    do_reset(2'b11);
    for (int ph = 0; ph < 12; ph++) begin
      for (int c = 0; c < 250; c++) begin
        int wp, rp;
        wp = (ph % 2 == 0) ? 80 : 30;
        rp = (ph % 2 == 0) ? 30 : 80;
        wr_cs_n = ($urandom_range(99) < 10);
        wr_en   = ($urandom_range(99) < wp);
        rd_cs_n = ($urandom_range(99) < 10);
        rd_en   = ($urandom_range(99) < rp);
        wr_data = {4'($urandom), 32'($urandom)};
        tick();
      end
    end

    // Phase 5: X = 8, fill then stream read and write together on every edge
    do_reset(2'b10);
    for (int i = 0; i < 66; i++) begin
      wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = 36'(i + 1000);
      tick();
    end
    for (int i = 0; i < 200; i++) begin
      wr_cs_n = 1'b0; wr_en = 1'b1; rd_cs_n = 1'b0; rd_en = 1'b1;
      wr_data = 36'(i + 5000);
      tick();
    end
    idle(); repeat (4) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule